// File: doc/BRIEF.md
# Code Word Serializer with Two-Bit CRC

This block turns one remote-control code word into a serial bit stream. A load transfer hands it a 32-bit rolling (hopping) value produced elsewhere, a 32-bit serial number, the pressed-button vector, the battery-low flag, two queue bits and three format options. In the normal format the word carries the hopping value, then a fixed part made of the serial number (either the low 28 bits plus a button function code, or all 32 bits), then a status tail. In the seed format a 60-bit seed and an all-ones function code replace the first 64 bits. The status tail is the battery-low flag, a two-bit CRC computed as the bits go out, and optionally the two queue bits, giving 67 or 69 bits.

Both edges are valid/ready streams. The load side accepts one word when the block is idle (`ld_ready` high) and refuses further loads until the last bit of that word has been taken. The output side offers one bit at a time with `out_valid`; the bit advances only on a cycle where `out_valid` and `out_ready` are both high, and a consumer may hold `out_ready` low for any number of cycles without loss. `out_last` marks the final bit and `out_len` gives the length of the word being sent.

Top module: `codeword_serializer`

## Requirements
- R1: `ld_ready` is high exactly when no word is being sent; a load happens on a clock edge with `ld_valid` and `ld_ready` both high, and `ld_ready` drops from the next cycle until the edge that accepts the last bit.
- R2: All inputs are captured at the load edge; changes on any input, including `ld_valid` pulses, while a word is being sent alter neither the bits, `out_last` nor `out_len`.
- R3: In the normal format, stream positions 0 to 31 are `in_hop` bits 0 to 31, least significant first.
- R4: In the normal format with `cfg_full_serial` low, positions 32 to 59 are `in_serial` bits 0 to 27, and positions 60, 61, 62, 63 carry buttons S3, S0, S1, S2 (`in_btn` bits 3, 0, 1, 2); every pressed button sets its own position, so simultaneous buttons combine by OR.
- R5: In the normal format with `cfg_full_serial` high, positions 32 to 63 are `in_serial` bits 0 to 31.
- R6: Position 64 is `in_vlow`; positions 67 and 68 are `in_queue` bits 0 and 1 when `cfg_queue_en` is high; `out_len` is 69 with queue bits and 67 without, and `out_last` is high only on the final position.
- R7: Positions 65 and 66 are CRC bits c0 and c1; both start at zero for each word and, for each of positions 0 to 64 in order with bit d, next c1 = c0 xor d and next c0 = c0 xor d xor c1, using the old values.
- R8: With `cfg_seed` high, positions 0 to 59 are `in_seed` bits 0 to 59 and positions 60 to 63 are all ones; `in_hop`, `in_serial`, `in_btn` and `cfg_full_serial` have no effect; the tail follows R6 and R7.
- R9: While `out_valid` is high and `out_ready` is low, `out_bit`, `out_last` and the stream position hold; exactly one position is consumed per accepted transfer.
- R10: After reset `out_valid` is low, `ld_ready` is high and `out_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Block idle, load accepted |
| in_hop | input | 32 | Rolling (hopping) value |
| in_serial | input | 32 | Serial number |
| in_seed | input | 60 | Seed value for the seed format |
| in_btn | input | 4 | Pressed buttons, bit n is button Sn |
| in_vlow | input | 1 | Battery-low flag |
| in_queue | input | 2 | Queue bits |
| cfg_full_serial | input | 1 | Fixed part is the full 32-bit serial |
| cfg_queue_en | input | 1 | Append queue bits |
| cfg_seed | input | 1 | Send the seed format |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | Current stream bit |
| out_last | output | 1 | Current bit is the final one |
| out_len | output | 7 | Length of the current word |

## Verification
A stuck or skipped stream position shows at once as a wrong `out_bit` or a misplaced `out_last`, within the cycle the fault occurs. A fault in the CRC register stays hidden until positions 65 and 66, up to 65 accepted transfers later, so every word is compared bit by bit including the tail, across formats, option mixes and random back-pressure. A busy flag that clears early or late is visible on `ld_ready` and `out_valid` in the same cycle, and captured fields that leak from the live inputs show as mismatches because inputs are scrambled throughout every transmission.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int HOP_W       = 32;
  localparam int SER_W       = 32;
  localparam int SER_SHORT_W = 28;
  localparam int BTN_W       = 4;
  localparam int SEED_W      = 60;
  localparam int QUE_W       = 2;
  localparam int CRC_W       = 2;

  localparam int BODY_W    = HOP_W + SER_W;
  localparam int BODY_AW   = $clog2(BODY_W);
  localparam int CRC_COVER = BODY_W + 1;
  localparam int LEN_BASE  = CRC_COVER + CRC_W;
  localparam int LEN_MAX   = LEN_BASE + QUE_W;
  localparam int IDX_W     = $clog2(LEN_MAX + 1);

  typedef struct packed {
    logic [HOP_W-1:0]  hop;
    logic [SER_W-1:0]  serial;
    logic [SEED_W-1:0] seed;
    logic [BTN_W-1:0]  btn;
    logic              vlow;
    logic [QUE_W-1:0]  que;
    logic              full_ser;
    logic              seed_mode;
  } cw_fields_t;

  // Function code order from the low end: S3, S0, S1, S2
  function automatic logic [BTN_W-1:0] func_code(input logic [BTN_W-1:0] b);
    return {b[2], b[1], b[0], b[3]};
  endfunction
endpackage

// File: rtl/cw_seq.sv
module cw_seq
  import cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             out_ready,
  input  logic [IDX_W-1:0] len_in,
  output logic             busy,
  output logic             ld_ready,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] len_q
);
  assign ld_ready = !busy;
  assign load     = ld_valid && !busy;
  assign step     = busy && out_ready;
  assign last     = busy && (idx == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      idx   <= '0;
      len_q <= len_in;
    end else if (step) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(idx)); // R9
  AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < len_q); // R6
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    step && last |=> !busy); // R1
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q == IDX_W'(LEN_BASE)) || (len_q == IDX_W'(LEN_MAX))); // R6
endmodule

// File: rtl/cw_crc2.sv
module cw_crc2
  import cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             d,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (clear)  crc <= '0;
    else if (en)     crc <= {crc[0] ^ d, crc[0] ^ d ^ crc[1]};
  end

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> crc == '0); // R7
  AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !en |=> $stable(crc)); // R7
endmodule

// File: rtl/cw_bitsel.sv
module cw_bitsel
  import cw_pkg::*;
(
  input  cw_fields_t       f,
  input  logic [IDX_W-1:0] idx,
  input  logic [CRC_W-1:0] crc,
  output logic             bit_o
);
  logic [SER_W-1:0]  fixed_part;
  logic [BODY_W-1:0] body;

  always_comb begin
    fixed_part = f.full_ser ? f.serial
                            : {func_code(f.btn), f.serial[SER_SHORT_W-1:0]};
    body = f.seed_mode ? {{BTN_W{1'b1}}, f.seed} : {fixed_part, f.hop};
    if (idx < IDX_W'(BODY_W)) begin
      bit_o = body[idx[BODY_AW-1:0]];
    end else begin
      unique case (idx)
        IDX_W'(BODY_W):     bit_o = f.vlow;
        IDX_W'(BODY_W + 1): bit_o = crc[0];
        IDX_W'(BODY_W + 2): bit_o = crc[1];
        IDX_W'(BODY_W + 3): bit_o = f.que[0];
        IDX_W'(BODY_W + 4): bit_o = f.que[1];
        default:            bit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/codeword_serializer.sv
module codeword_serializer
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [HOP_W-1:0]  in_hop,
  input  logic [SER_W-1:0]  in_serial,
  input  logic [SEED_W-1:0] in_seed,
  input  logic [BTN_W-1:0]  in_btn,
  input  logic              in_vlow,
  input  logic [QUE_W-1:0]  in_queue,
  input  logic              cfg_full_serial,
  input  logic              cfg_queue_en,
  input  logic              cfg_seed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              out_last,
  output logic [IDX_W-1:0]  out_len
);
  cw_fields_t       fields_q;
  logic             busy, load, step, last;
  logic [IDX_W-1:0] idx, len_q, len_in;
  logic [CRC_W-1:0] crc;
  logic             crc_en;

  assign len_in = cfg_queue_en ? IDX_W'(LEN_MAX) : IDX_W'(LEN_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (load) begin
      fields_q.hop       <= in_hop;
      fields_q.serial    <= in_serial;
      fields_q.seed      <= in_seed;
      fields_q.btn       <= in_btn;
      fields_q.vlow      <= in_vlow;
      fields_q.que       <= cfg_queue_en ? in_queue : '0;
      fields_q.full_ser  <= cfg_full_serial;
      fields_q.seed_mode <= cfg_seed;
    end
  end

  cw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .out_ready(out_ready),
    .len_in(len_in), .busy(busy), .ld_ready(ld_ready), .load(load),
    .step(step), .last(last), .idx(idx), .len_q(len_q)
  );

  cw_bitsel u_sel (.f(fields_q), .idx(idx), .crc(crc), .bit_o(out_bit));

  assign crc_en = step && (idx < IDX_W'(CRC_COVER));

  cw_crc2 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(load), .en(crc_en), .d(out_bit), .crc(crc)
  );

  assign out_valid = busy;
  assign out_last  = last;
  assign out_len   = len_q;

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fields_q)); // R2
  AST_BIT_STABLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last)); // R9
  AST_CRC_FROZEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (idx >= IDX_W'(CRC_COVER)) |=> $stable(crc)); // R7
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ld_ready); // R1
endmodule

// File: tb/codeword_serializer_test.sv
module codeword_serializer_test;
  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_ready;
  logic [31:0] in_hop = 0, in_serial = 0;
  logic [59:0] in_seed = 0;
  logic [3:0]  in_btn = 0;
  logic        in_vlow = 0;
  logic [1:0]  in_queue = 0;
  logic cfg_full_serial = 0, cfg_queue_en = 0, cfg_seed = 0;
  logic out_valid, out_ready = 0, out_bit, out_last;
  logic [6:0] out_len;

  int errors = 0, checks = 0;
  logic        started = 0;
  logic        m_busy = 0, m_sm = 0, m_full = 0;
  logic [68:0] m_word = '0;
  int          m_idx = 0, m_len = 0;

  always #5 clk = ~clk;

  codeword_serializer uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .in_hop(in_hop), .in_serial(in_serial), .in_seed(in_seed), .in_btn(in_btn),
    .in_vlow(in_vlow), .in_queue(in_queue), .cfg_full_serial(cfg_full_serial),
    .cfg_queue_en(cfg_queue_en), .cfg_seed(cfg_seed), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last), .out_len(out_len)
  );

  function automatic logic [68:0] build_word();
    logic [68:0] w = '0;
    logic c0 = 0, c1 = 0, n0, n1;
    if (cfg_seed) begin
      w[59:0] = in_seed; w[63:60] = 4'b1111;            // R8
    end else begin
      w[31:0] = in_hop;                                 // R3
      if (cfg_full_serial) w[63:32] = in_serial;        // R5
      else begin                                        // R4
        w[59:32] = in_serial[27:0];
        w[60] = in_btn[3]; w[61] = in_btn[0]; w[62] = in_btn[1]; w[63] = in_btn[2];
      end
    end
    w[64] = in_vlow;                                    // R6
    for (int i = 0; i < 65; i++) begin                  // R7
      n1 = c0 ^ w[i]; n0 = c0 ^ w[i] ^ c1; c0 = n0; c1 = n1;
    end
    w[65] = c0; w[66] = c1;
    if (cfg_queue_en) begin w[67] = in_queue[0]; w[68] = in_queue[1]; end
    return w;
  endfunction

  function automatic string req_of(int i, logic sm, logic full);
    if (i < 64) begin
      if (sm) return "R8";
      if (i < 32) return "R3";
      return full ? "R5" : "R4";
    end
    if (i == 65 || i == 66) return "R7";
    return "R6";
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, advanced on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_idx <= 0; m_len <= 0;
    end else if (m_busy) begin
      if (out_ready) begin
        if (m_idx == m_len - 1) m_busy <= 0;
        else m_idx <= m_idx + 1;
      end
    end else if (ld_valid) begin
      m_word <= build_word(); m_len <= cfg_queue_en ? 69 : 67;
      m_sm <= cfg_seed; m_full <= cfg_full_serial; m_busy <= 1; m_idx <= 0;
    end
  end

  // Comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk(ld_ready === !m_busy, "R1 ld_ready", 32'(ld_ready), 32'(!m_busy));
      chk(out_valid === m_busy, "R9 out_valid", 32'(out_valid), 32'(m_busy));
      if (m_busy) begin
        chk(out_bit === m_word[m_idx], $sformatf("%s bit %0d", req_of(m_idx, m_sm, m_full), m_idx),
            32'(out_bit), 32'(m_word[m_idx]));
        chk(out_last === (m_idx == m_len - 1), "R6 out_last", 32'(out_last), 32'(m_idx == m_len - 1));
        chk(out_len === 7'(m_len), "R2 out_len held", 32'(out_len), 32'(m_len));
      end
    end
  end

  task automatic scramble();
    in_hop = $urandom; in_serial = $urandom; in_seed = {$urandom, $urandom};
    in_btn = 4'($urandom); in_vlow = 1'($urandom); in_queue = 2'($urandom);
    cfg_full_serial = 1'($urandom); cfg_queue_en = 1'($urandom); cfg_seed = 1'($urandom);
  endtask

  task automatic send(input logic [31:0] hop, input logic [31:0] ser, input logic [59:0] seed,
                      input logic [3:0] btn, input logic vl, input logic [1:0] q,
                      input logic full, input logic qen, input logic sm);
    while (m_busy) @(negedge clk);
    in_hop = hop; in_serial = ser; in_seed = seed; in_btn = btn; in_vlow = vl;
    in_queue = q; cfg_full_serial = full; cfg_queue_en = qen; cfg_seed = sm;
    ld_valid = 1;
    @(negedge clk);
    while (m_busy) begin   // R2: inputs and load requests change during the word
      scramble();
      ld_valid = 1'($urandom);
      @(negedge clk);
    end
    ld_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset out_valid", 32'(out_valid), 0);
    chk(ld_ready === 1'b1, "R10 reset ld_ready", 32'(ld_ready), 1);
    chk(out_len === 7'd0, "R10 reset out_len", 32'(out_len), 0);
    started = 1;
    send('0, '0, '0, 4'h0, 0, 2'b00, 0, 0, 0);                    // all zero, CRC 00
    send('0, '0, '0, 4'h0, 1, 2'b00, 0, 0, 0);                    // only vlow, CRC 11
    send(32'hA5C3_0F96, 32'h1234_5678, '0, 4'b0001, 0, 2'b10, 0, 1, 0);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, 4'hF, 1, 2'b11, 1, 1, 0);
    send(32'h0000_0001, 32'h8000_0000, '0, 4'b0101, 0, 2'b01, 0, 0, 0);
    send(32'h1357_9BDF, 32'hCAFE_F00D, 60'h0FED_CBA9_8765_432, 4'b1010, 1, 2'b01, 1, 0, 1);
    send(32'h0, 32'h0, 60'hFFF_FFFF_FFFF_FFFF, 4'h0, 0, 2'b10, 0, 1, 1);
    send(32'h0, 32'h0, 60'h1, 4'h8, 1, 2'b00, 1, 1, 1);
    for (int k = 0; k < 24; k++)
      send($urandom, $urandom, {$urandom, $urandom}, 4'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule